// File: doc/BRIEF.md
# Trigger-to-Strobe Phase Time-to-Digital Converter

This block measures how far an asynchronous trigger lands from the next edge of a slow, periodic stop strobe. The stop strobe rises once every fourth cycle of the 40 MHz system clock, so it is a 10 MHz signal that is high a quarter of the time. The reading tells later logic whether the trigger was in step with the switching of the front-end pipeline, so that events can be kept or dropped on that basis.

All logic runs on a fast measurement clock of about 280 MHz, which comes from outside the block. Both the trigger and the strobe pass through synchronisers of the same depth, so their fixed latency cancels out of the measurement. A free-running counter of `CNT_W` bits provides the time stamps. The counter value is captured on the trigger's rising edge and again on the first strobe rising edge after it. The difference of the two, taken modulo 2^`CNT_W`, is given as an `OUT_W`-bit code. A one-cycle `done` pulse marks each new code. The code is held, with `resultValid` high, until the consumer raises `ackIn`. Triggers that arrive before then are dropped. With 28 fast cycles per strobe period the 6-bit code covers the 100 ns window in steps of about 3.6 ns. Finer interpolation is not part of the block.

Top module: `phase_tdc`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `code` is zero and `resultValid` and `done` are low.
- R2: A measurement starts only on a rising edge of the synchronised trigger while the block is idle. A trigger level held high across a return to idle does not start one.
- R3: The stop point is the first synchronised strobe rising edge in a cycle strictly later than the start cycle. `code` equals the number of fast clock cycles between the start and the stop. A strobe edge in the same cycle as the trigger edge therefore gives a full strobe period (28 with a strobe period of 28 cycles).
- R4: The difference is computed modulo 2^`CNT_W`, so it is correct when the counter wraps between start and stop. The upper `OUT_W`-`CNT_W` bits of `code` are zero.
- R5: `done` is high for exactly one cycle per measurement, in the cycle where `resultValid` first goes high and the new `code` first appears.
- R6: `code` and `resultValid` stay unchanged until `ackIn` is sampled high while `resultValid` is high. One cycle after that, `resultValid` is low.
- R7: Trigger rising edges that arrive while a measurement is waiting for its stop, or while a result is held, have no effect on the start stamp, the code or the state.
- R8: `ackIn` while no result is held has no effect: no `done` pulse, `resultValid` stays low, and the next measurement is correct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast measurement clock (about 280 MHz) |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Asynchronous trigger; its rising edge starts a measurement |
| strobeIn | input | 1 | Stop strobe, one rising edge per four system clocks |
| ackIn | input | 1 | Consumer has taken the held code |
| code | output | OUT_W (6) | Start-to-stop interval in fast clock cycles |
| resultValid | output | 1 | A code is held and not yet acknowledged |
| done | output | 1 | One-cycle pulse when a new code appears |

## Verification
The embedded assertions check on every cycle that `done` lasts one cycle and comes with `resultValid`, and that the held code stays stable until it is acknowledged. They also check that an acknowledge clears the hold, that start and stop stamps are taken only on detected edges, and that a trigger edge while armed does not disturb the measurement. Only the bench scenarios can show that the numeric code is right. The bench sweeps all 28 trigger phases against the strobe, twice, with varying counter alignment so that the counter wraps inside the interval. It also covers the same-cycle case, which gives a full period. Whether triggers while busy, a level held high and a stray acknowledge are really ignored can likewise only be seen from the bench's scenarios.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchStart;  // capture start stamp this cycle
    logic latchStop;   // capture stop stamp and form the code this cycle
  } tdcCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_HOLD  = 2'd2
  } tdcState_t;

endpackage

// File: rtl/tdc_sync.sv
module tdc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/tdc_datapath.sv
module tdc_datapath
  import tdc_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int OUT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             strobeIn,
  input  tdcCtrl_t         ctl,
  output logic             trigRise,
  output logic             strobeRise,
  output logic [OUT_W-1:0] code
);

  localparam int N_IN = 2;  // index 0 = trigger, 1 = strobe

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] syncIn;
  logic [N_IN-1:0] syncPrev;
  logic [N_IN-1:0] riseIn;

  assign rawIn = {strobeIn, trigIn};

  // Equal-depth synchronisers so the fixed latency cancels in the difference
  for (genvar gi = 0; gi < N_IN; gi++) begin : g_in
    tdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (rawIn[gi]),
      .dout (syncIn[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) syncPrev <= '0;
    else       syncPrev <= syncIn;
  end

  assign riseIn     = syncIn & ~syncPrev;
  assign trigRise   = riseIn[0];
  assign strobeRise = riseIn[1];

  // Free-running time base
  logic [CNT_W-1:0] stampCnt;
  logic [CNT_W-1:0] startStamp;
  logic [CNT_W-1:0] intervalMod;
  logic [OUT_W-1:0] codeQ;

  always_ff @(posedge clk) begin
    if (!rstN) stampCnt <= '0;
    else       stampCnt <= stampCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               startStamp <= '0;
    else if (ctl.latchStart) startStamp <= stampCnt;
  end

  // Modulo 2^CNT_W difference: wraparound between stamps cancels
  assign intervalMod = stampCnt - startStamp;

  always_ff @(posedge clk) begin
    if (!rstN)              codeQ <= '0;
    else if (ctl.latchStop) codeQ <= OUT_W'(intervalMod);
  end

  assign code = codeQ;

  // R2: a start stamp is only taken on a detected trigger edge
  p_start_on_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchStart |-> trigRise);

  // R3: a stop stamp is only taken on a detected strobe edge
  p_stop_on_edge_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchStop |-> strobeRise);

  // R1: the code is cleared by reset
  p_reset_code_r1: assert property (@(posedge clk)
    !rstN |=> (code == '0));

endmodule

// File: rtl/tdc_control.sv
module tdc_control
  import tdc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     trigRise,
  input  logic     strobeRise,
  input  logic     ackIn,
  output tdcCtrl_t ctl,
  output logic     resultValid,
  output logic     done
);

  tdcState_t state, stateNext;
  logic      doneQ;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (trigRise) begin
          ctl.latchStart = 1'b1;
          stateNext      = ST_ARMED;
        end
      end
      ST_ARMED: begin
        // strictly later than the start cycle, since start happens in IDLE
        if (strobeRise) begin
          ctl.latchStop = 1'b1;
          stateNext     = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (ackIn) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= ctl.latchStop;
    end
  end

  assign resultValid = (state == ST_HOLD);
  assign done        = doneQ;

  // R5: done never lasts two cycles
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: a trigger edge while armed does not restart or leave the armed state
  p_armed_ignores_trig_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED) && trigRise && !strobeRise |=> (state == ST_ARMED));

  // R8: an acknowledge while idle leaves the block idle without a result
  p_idle_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && ackIn && !trigRise |=> !resultValid && !done);

endmodule

// File: rtl/phase_tdc.sv
module phase_tdc
  import tdc_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int OUT_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic             strobeIn,
  input  logic             ackIn,
  output logic [OUT_W-1:0] code,
  output logic             resultValid,
  output logic             done
);

  tdcCtrl_t ctl;
  logic     trigRise;
  logic     strobeRise;

  tdc_datapath #(
    .CNT_W       (CNT_W),
    .OUT_W       (OUT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .trigIn     (trigIn),
    .strobeIn   (strobeIn),
    .ctl        (ctl),
    .trigRise   (trigRise),
    .strobeRise (strobeRise),
    .code       (code)
  );

  tdc_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .trigRise    (trigRise),
    .strobeRise  (strobeRise),
    .ackIn       (ackIn),
    .ctl         (ctl),
    .resultValid (resultValid),
    .done        (done)
  );

  // R5: the done pulse comes with the held result
  p_done_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> resultValid);

  // R6: without acknowledge the result and its code are held
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid && !ackIn |=> resultValid && $stable(code));

  // R6: an acknowledge clears the hold
  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    resultValid && ackIn |=> !resultValid);

  // R4: bits above the counter width stay zero
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ((code >> CNT_W) == '0));

endmodule

// File: tb/phase_tdc_bench.sv
module phase_tdc_bench;

  localparam int CLK_PERIOD = 8;
  localparam int PERIOD     = 28;  // fast cycles per strobe period
  localparam int HIGH_LEN   = 7;   // 25 % duty

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       trigIn = 1'b0;
  logic       strobeIn = 1'b0;
  logic       ackIn = 1'b0;
  logic [5:0] code;
  logic       resultValid;
  logic       done;

  int ph = 0;
  int nTests = 0;
  int nFail = 0;
  int cycles = 0;

  phase_tdc u_phase_tdc (
    .clk         (clk),
    .rstN        (rstN),
    .trigIn      (trigIn),
    .strobeIn    (strobeIn),
    .ackIn       (ackIn),
    .code        (code),
    .resultValid (resultValid),
    .done        (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Strobe generator: phase counter advanced on falling edges
  always @(negedge clk) begin
    ph       <= (ph == PERIOD-1) ? 0 : ph + 1;
    strobeIn <= (((ph == PERIOD-1) ? 0 : ph + 1) < HIGH_LEN);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("[TB] FAIL watchdog expired (all requirements) actual=%0d expected<=150000", cycles);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  task automatic slot();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitPhase(input int p);
    do slot(); while (ph != p);
  endtask

  task automatic waitDone(output bit seen);
    int n;
    seen = 1'b0;
    n = 0;
    while (!seen && n < 64) begin
      slot();
      n++;
      if (done) seen = 1'b1;
    end
  endtask

  // Trigger rises in the same slot as strobe phase p; expected interval
  task automatic measure(input int p);
    int exp;
    bit seen;
    exp = (p == 0) ? PERIOD : PERIOD - p;
    waitPhase(p);
    trigIn = 1'b1;
    waitDone(seen);
    check(seen, "R5 done pulse after trigger", int'(seen), 1);
    check(code == 6'(exp), "R3 R4 interval code", int'(code), exp);
    check(resultValid, "R5 valid with done", int'(resultValid), 1);
    slot();
    check(!done, "R5 done single cycle", int'(done), 0);
    check(resultValid && code == 6'(exp), "R6 result held before ack", int'(code), exp);
    ackIn  = 1'b1;
    trigIn = 1'b0;
    slot();
    ackIn = 1'b0;
    check(!resultValid, "R6 ack clears valid", int'(resultValid), 0);
  endtask

  initial begin
    bit seen;
    bit bad;

    // R1: reset state
    repeat (3) slot();
    check(code == 6'd0 && !resultValid && !done, "R1 outputs during reset",
          int'({resultValid, done, code}), 0);
    rstN = 1'b1;
    slot();
    check(code == 6'd0 && !resultValid && !done, "R1 outputs after reset",
          int'({resultValid, done, code}), 0);
    repeat (4) slot();

    // R8: acknowledge while idle
    ackIn = 1'b1;
    slot();
    ackIn = 1'b0;
    bad = 1'b0;
    repeat (10) begin
      slot();
      if (done || resultValid) bad = 1'b1;
    end
    check(!bad, "R8 idle ack has no effect", int'(bad), 0);
    measure(5);

    // R3 R4: every trigger phase, two rounds (counter wraps inside intervals)
    for (int r = 0; r < 2; r++) begin
      for (int p = 0; p < PERIOD; p++) begin
        measure(p);
      end
    end

    // R7: second trigger edge while armed, third while holding
    waitPhase(10);
    trigIn = 1'b1;
    repeat (5) slot();
    trigIn = 1'b0;
    repeat (3) slot();
    trigIn = 1'b1;
    waitDone(seen);
    check(seen && code == 6'd18, "R7 retrigger while armed ignored", int'(code), 18);
    slot();
    trigIn = 1'b0;
    repeat (3) slot();
    trigIn = 1'b1;
    repeat (6) slot();
    check(resultValid && code == 6'd18, "R7 retrigger while holding ignored", int'(code), 18);
    ackIn = 1'b1;
    slot();
    ackIn = 1'b0;

    // R2 R7: trigger still high after return to idle must not start anything
    bad = 1'b0;
    repeat (40) begin
      slot();
      if (done || resultValid) bad = 1'b1;
    end
    check(!bad, "R2 R7 held trigger level starts no measurement", int'(bad), 0);
    trigIn = 1'b0;
    repeat (4) slot();

    // Measurement after the ignored edges is still exact
    measure(20);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule